// File: doc/BRIEF.md
# Debug Break-Loop Controller

This block decides how a small 8-bit CPU core enters its debug state when a break instruction comes out of the fetch stage. A break is the all-zero opcode, which is also what an erased-then-programmed flash byte reads as. Each fetch is checked against that opcode. If the host has left the loop-enable bit clear, the block halts the core in debug mode on the next cycle. If the loop-enable bit is set, the core instead spins on the break. It requests the core to keep refetching it, raises an idle flag the host can poll, and remembers the break's address. Interrupts can still draw the core away into a service routine during the spin.

To turn a spin into a real halt, the host clears the loop-enable bit rather than forcing debug mode. This lets the core finish any service routine it is in. When a break is next fetched at the remembered address, the block enters debug mode by itself. The debug command decoder is enabled only in debug mode, never during a spin. A host write that clears the debug bit resumes execution and forgets the remembered address.

Top module: `brk_loop_ctl`

## Requirements
- R1: After reset, dbg_mode, idle, cmd_en, core_spin and core_hold are all 0, and the loop-enable bit is 0.
- R2: A break is recognised only when fetch_vld is 1 and fetch_op equals 8'h00. Any other opcode, or a zero opcode without fetch_vld, leaves every output unchanged.
- R3: In the running state with loop-enable clear, a break fetch sets dbg_mode and core_hold on the next cycle, while idle stays 0.
- R4: In the running state with loop-enable set, a break fetch sets idle and core_spin on the next cycle, latches fetch_pc, and keeps dbg_mode at 0.
- R5: While spinning, core_spin is 0 in any cycle in which irq_active is 1, and idle stays 1.
- R6: While spinning, a break fetched at the latched address with loop-enable clear sets dbg_mode on the next cycle and clears idle.
- R7: While spinning, a break fetched at any other address has no effect.
- R8: cmd_en is 1 exactly when dbg_mode is 1, so it is 0 throughout a spin.
- R9: In debug mode, a control write with the debug bit 0 returns to running on the next cycle. All flags go to 0 and the latched address is discarded, so a later spin latches its own break address.
- R10: A control write with the debug bit 1 enters debug mode on the next cycle from running, but is ignored while spinning.
- R11: In debug mode, fetches are ignored and debug mode persists until a resume write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_vld | input | 1 | Fetch stage presents a valid opcode |
| fetch_op | input | 8 | Fetched opcode |
| fetch_pc | input | PC_W | Address of the fetched opcode |
| irq_active | input | 1 | Core is vectoring to or running an interrupt service |
| ctl_wr | input | 1 | Host writes the control bits this cycle |
| ctl_loop | input | 1 | Loop-enable value written |
| ctl_dbg | input | 1 | Debug-mode value written |
| dbg_mode | output | 1 | Core is halted in debug mode |
| idle | output | 1 | Core is spinning on a break |
| cmd_en | output | 1 | Debug command decoder enable |
| core_spin | output | 1 | Request to refetch the break in place |
| core_hold | output | 1 | Stall request to the core |

## Verification
A wrong state register shows at the ports on the cycle after the fetch or write that should have moved it. Examples are idle with dbg_mode, or cmd_en during a spin. A stale or badly loaded break address stays hidden during a spin. It only shows when the host clears loop-enable and a break is fetched at the true address, or at the stale one: dbg_mode then fails to rise, or rises one cycle after the wrong fetch. A loop-enable bit that is not stored appears at the next break fetch from the running state, as a halt where a spin was due, or the reverse.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SPIN = 2'd1,
    ST_HALT = 2'd2
  } brk_state_t;

  // True when a fetched byte is the break opcode.
  function automatic logic op_is_brk(input logic [7:0] op, input logic [7:0] brk_code);
    return (op == brk_code);
  endfunction

endpackage

// File: rtl/brk_decode.sv
module brk_decode #(
  parameter int OP_W = 8,
  parameter logic [7:0] BRK_CODE = 8'h00
) (
  input  logic            fetch_vld,
  input  logic [OP_W-1:0] fetch_op,
  output logic            brk_hit
);
  import brk_pkg::*;

  always_comb begin
    brk_hit = fetch_vld && op_is_brk(fetch_op, BRK_CODE);
  end

endmodule

// File: rtl/brk_addr_reg.sv
module brk_addr_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            clr,
  input  logic [PC_W-1:0] pc_in,
  output logic            pc_match
);
  logic [PC_W-1:0] held_pc;
  logic            held_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_pc  <= '0;
      held_vld <= 1'b0;
    end else if (clr) begin
      held_pc  <= '0;
      held_vld <= 1'b0;
    end else if (load) begin
      held_pc  <= pc_in;
      held_vld <= 1'b1;
    end
  end

  always_comb begin
    pc_match = held_vld && (pc_in == held_pc);
  end

endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       brk_hit,
  input  logic       pc_match,
  input  logic       irq_active,
  input  logic       ctl_wr,
  input  logic       ctl_loop,
  input  logic       ctl_dbg,
  output brk_state_t state,
  output logic       loop_q,
  output logic       load_pc,
  output logic       clr_pc
);
  brk_state_t nxt;
  logic host_set_dbg;
  logic host_resume;

  always_comb begin
    host_set_dbg = ctl_wr && ctl_dbg;
    host_resume  = ctl_wr && !ctl_dbg;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN: begin
        if (host_set_dbg)  nxt = ST_HALT;
        else if (brk_hit)  nxt = loop_q ? ST_SPIN : ST_HALT;
      end
      ST_SPIN: begin
        if (brk_hit && pc_match && !loop_q) nxt = ST_HALT;
      end
      ST_HALT: begin
        if (host_resume) nxt = ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_comb begin
    load_pc = (state == ST_RUN) && !host_set_dbg && brk_hit && loop_q;
    clr_pc  = (state == ST_HALT) && host_resume;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      loop_q <= 1'b0;
    end else begin
      state <= nxt;
      if (ctl_wr) loop_q <= ctl_loop;
    end
  end

  // irq_active is consumed at the top level for the spin request.
  logic unused_irq;
  always_comb unused_irq = irq_active;

endmodule

// File: rtl/brk_loop_ctl.sv
module brk_loop_ctl
  import brk_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int OP_W = 8,
  parameter logic [7:0] BRK_CODE = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_vld,
  input  logic [OP_W-1:0] fetch_op,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            irq_active,
  input  logic            ctl_wr,
  input  logic            ctl_loop,
  input  logic            ctl_dbg,
  output logic            dbg_mode,
  output logic            idle,
  output logic            cmd_en,
  output logic            core_spin,
  output logic            core_hold
);
  brk_state_t state;
  logic brk_hit, pc_match, loop_q, load_pc, clr_pc;
  logic run_st, spin_st, halt_st;

  brk_decode #(.OP_W(OP_W), .BRK_CODE(BRK_CODE)) u_dec (
    .fetch_vld (fetch_vld),
    .fetch_op  (fetch_op),
    .brk_hit   (brk_hit)
  );

  brk_addr_reg #(.PC_W(PC_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_pc),
    .clr      (clr_pc),
    .pc_in    (fetch_pc),
    .pc_match (pc_match)
  );

  brk_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .brk_hit    (brk_hit),
    .pc_match   (pc_match),
    .irq_active (irq_active),
    .ctl_wr     (ctl_wr),
    .ctl_loop   (ctl_loop),
    .ctl_dbg    (ctl_dbg),
    .state      (state),
    .loop_q     (loop_q),
    .load_pc    (load_pc),
    .clr_pc     (clr_pc)
  );

  always_comb begin
    run_st    = (state == ST_RUN);
    spin_st   = (state == ST_SPIN);
    halt_st   = (state == ST_HALT);
    dbg_mode  = halt_st;
    idle      = spin_st;
    cmd_en    = halt_st;
    core_hold = halt_st;
    core_spin = spin_st && !irq_active;
  end

endmodule

// File: rtl/brk_ctl_chk.sv
module brk_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic brk_hit,
  input logic pc_match,
  input logic loop_q,
  input logic run_st,
  input logic spin_st,
  input logic irq_active,
  input logic ctl_wr,
  input logic ctl_dbg,
  input logic dbg_mode,
  input logic idle,
  input logic cmd_en,
  input logic core_spin
);
  AST_CMD_ONLY_DBG: assert property (@(posedge clk) disable iff (!rst_n) cmd_en |-> dbg_mode); // R8
  AST_IDLE_EXCL_DBG: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !dbg_mode); // R4
  AST_DIRECT_HALT: assert property (@(posedge clk) disable iff (!rst_n) run_st && brk_hit && !loop_q |=> dbg_mode && !idle); // R3
  AST_SPIN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) run_st && brk_hit && loop_q && !(ctl_wr && ctl_dbg) |=> idle); // R4
  AST_IRQ_NO_SPIN: assert property (@(posedge clk) disable iff (!rst_n) idle && irq_active |-> !core_spin); // R5
  AST_RETURN_HALT: assert property (@(posedge clk) disable iff (!rst_n) spin_st && brk_hit && pc_match && !loop_q |=> dbg_mode); // R6
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n) dbg_mode && ctl_wr && !ctl_dbg |=> !dbg_mode && !idle); // R9
  AST_SPIN_IGNORES_DBG: assert property (@(posedge clk) disable iff (!rst_n) spin_st && !(brk_hit && pc_match && !loop_q) |=> !dbg_mode); // R10
  AST_DBG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) dbg_mode && !(ctl_wr && !ctl_dbg) |=> dbg_mode); // R11
endmodule

bind brk_loop_ctl brk_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .brk_hit    (brk_hit),
  .pc_match   (pc_match),
  .loop_q     (loop_q),
  .run_st     (run_st),
  .spin_st    (spin_st),
  .irq_active (irq_active),
  .ctl_wr     (ctl_wr),
  .ctl_dbg    (ctl_dbg),
  .dbg_mode   (dbg_mode),
  .idle       (idle),
  .cmd_en     (cmd_en),
  .core_spin  (core_spin)
);

// File: tb/sim_brk_loop_ctl.sv
module sim_brk_loop_ctl;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_vld = 1'b0;
  logic [7:0] fetch_op = 8'hFF;
  logic [PC_W-1:0] fetch_pc = '0;
  logic irq_active = 1'b0;
  logic ctl_wr = 1'b0, ctl_loop = 1'b0, ctl_dbg = 1'b0;
  logic dbg_mode, idle, cmd_en, core_spin, core_hold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  brk_loop_ctl #(.PC_W(PC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_op(fetch_op),
    .fetch_pc(fetch_pc), .irq_active(irq_active), .ctl_wr(ctl_wr),
    .ctl_loop(ctl_loop), .ctl_dbg(ctl_dbg), .dbg_mode(dbg_mode), .idle(idle),
    .cmd_en(cmd_en), .core_spin(core_spin), .core_hold(core_hold)
  );

  // flags packed as {dbg_mode, idle, cmd_en, core_spin, core_hold}
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {dbg_mode, idle, cmd_en, core_spin, core_hold};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: flags got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] op, input logic [PC_W-1:0] pc, input logic vld);
    fetch_vld = vld; fetch_op = op; fetch_pc = pc;
    @(negedge clk);
    fetch_vld = 1'b0; fetch_op = 8'hFF;
  endtask

  task automatic host_wr(input logic loop_v, input logic dbg_v);
    ctl_wr = 1'b1; ctl_loop = loop_v; ctl_dbg = dbg_v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  localparam logic [4:0] F_RUN  = 5'b00000;
  localparam logic [4:0] F_HALT = 5'b10101;
  localparam logic [4:0] F_SPIN = 5'b01010;
  localparam logic [4:0] F_SPIN_IRQ = 5'b01000;

  task automatic t_reset();
    chk("R1 reset flags", F_RUN);
    fetch(8'h00, 16'h0010, 1'b1); // loop bit must be 0 after reset
    chk("R1 loop bit reset clear", F_HALT);
    host_wr(1'b0, 1'b0);
    chk("R9 resume after reset test", F_RUN);
  endtask

  task automatic t_non_break();
    fetch(8'h3A, 16'h0100, 1'b1);
    chk("R2 other opcode ignored", F_RUN);
    fetch(8'h00, 16'h0101, 1'b0);
    chk("R2 break without valid ignored", F_RUN);
  endtask

  task automatic t_direct_halt();
    fetch(8'h00, 16'h0120, 1'b1);
    chk("R3 R8 direct halt", F_HALT);
    fetch(8'h00, 16'h0121, 1'b1);
    chk("R11 fetch in debug ignored", F_HALT);
    host_wr(1'b0, 1'b0);
    chk("R9 resume", F_RUN);
  endtask

  task automatic t_spin();
    host_wr(1'b1, 1'b0);
    chk("R2 loop write alone no effect", F_RUN);
    fetch(8'h00, 16'h0200, 1'b1);
    chk("R4 R8 spin entry", F_SPIN);
    irq_active = 1'b1;
    #1;
    chk("R5 irq drops spin", F_SPIN_IRQ);
    host_wr(1'b0, 1'b0);
    chk("R5 loop cleared still spinning", F_SPIN_IRQ);
    fetch(8'h00, 16'h0300, 1'b1);
    chk("R7 other address ignored", F_SPIN_IRQ);
    host_wr(1'b0, 1'b1);
    chk("R10 host debug ignored in spin", F_SPIN_IRQ);
    irq_active = 1'b0;
    #1;
    chk("R5 spin back after irq", F_SPIN);
    fetch(8'h00, 16'h0200, 1'b1);
    chk("R6 return halts", F_HALT);
    host_wr(1'b0, 1'b0);
    chk("R9 resume from loop halt", F_RUN);
  endtask

  task automatic t_relatch();
    host_wr(1'b1, 1'b0);
    fetch(8'h00, 16'h0050, 1'b1);
    chk("R9 new spin", F_SPIN);
    host_wr(1'b0, 1'b0);
    fetch(8'h00, 16'h0200, 1'b1);
    chk("R9 old address forgotten", F_SPIN);
    fetch(8'h00, 16'h0050, 1'b1);
    chk("R6 new address halts", F_HALT);
    host_wr(1'b0, 1'b0);
    chk("R9 resume again", F_RUN);
  endtask

  task automatic t_host_halt();
    host_wr(1'b0, 1'b1);
    chk("R10 host debug from run", F_HALT);
    host_wr(1'b0, 1'b1);
    chk("R11 debug write holds", F_HALT);
    host_wr(1'b0, 1'b0);
    chk("R9 resume from host halt", F_RUN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_non_break();
    t_direct_halt();
    t_spin();
    t_relatch();
    t_host_halt();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule